// File: doc/BRIEF.md
# Idle Flow Timeout Scanner

This block remembers, for every location of a flow table, the second at which a packet of that flow was last seen. It reports each location that has been silent for a configurable number of seconds. Each time a packet's flow location is presented with its strobe, the current seconds value goes into a two-port timestamp memory at that location. A background walker reads the memory through the second port, one entry every two cycles. It compares each stored time with the running seconds counter. When an entry has aged out, the walker raises a one-cycle delete pulse carrying the location and writes zero back into the entry. Removing the flow from the table itself is left to the consumer of the pulse.

The seconds counter advances after a parameterised number of microsecond tick pulses. It starts at 1 and skips 0 when it wraps, because a stored 0 marks an unused entry. Ages are measured cyclically, so wraparound of the counter is handled. The walker is a three-state machine. WIPE zeroes every entry after reset. FETCH issues the read of one entry. JUDGE compares that entry and clears it if it has expired. The transitions are WIPE to FETCH after the last location, FETCH to JUDGE always, and JUDGE to FETCH always, with the address stepping up on every WIPE and JUDGE cycle.

Top module: `idle_flow_scanner`

## Requirements
- R1: After reset is released, the walker spends exactly 2^LOC_W cycles in WIPE writing 0 to every entry, and del_valid stays low from reset through that period.
- R2: The seconds counter starts at 1. It advances by one after every PRESCALE cycles in which tick_us is high, and after 2^TS_W-1 it continues at 1, never holding 0.
- R3: A cycle with pkt_valid high stores the current seconds value into the entry at pkt_loc.
- R4: After WIPE, entries are visited in ascending order and wrap around, one every two cycles. Counting edges from the first rising edge after release as edge 0, entry a is read in the cycle after edge 2^LOC_W-1+2a+2·2^LOC_W·s and judged in the following cycle (sweep s).
- R5: A judged entry whose stored value is non-zero and whose age is at least TIMEOUT produces del_valid high for the one cycle after the judge cycle, with del_loc equal to that entry. The entry is then zeroed, so each write produces at most one report.
- R6: An entry holding 0 is never reported, whatever the time.
- R7: Age is the cyclic distance from the stored value to the current value over the sequence 1..2^TS_W-1, so a report comes exactly TIMEOUT seconds after the last write even across counter wraparound.
- R8: A packet write to the entry being read or judged, in the read cycle or the judge cycle, wins. No delete is issued for that visit, and the new time stays stored.
- R9: del_valid is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | Microsecond enable pulse feeding the seconds prescaler |
| pkt_valid | input | 1 | A packet for flow location pkt_loc is seen this cycle |
| pkt_loc | input | LOC_W | Flow location of the packet |
| del_valid | output | 1 | One-cycle pulse: the flow at del_loc has gone idle |
| del_loc | output | LOC_W | Location of the idle flow |

## Verification
The bench runs a small configuration: eight entries, a four-bit counter that wraps twice during the run, and a three-second timeout. Every report is checked against the seconds counted in absolute terms. A design that measured age by plain subtraction would report too early or too late after a wrap, and one that compared with a strict inequality would be a second late. A quiet period with no writes catches a design that reports unused zero entries. A location refreshed every second must never be reported. Two packet writes are placed, from the scan cadence alone, into exactly the read cycle and the judge cycle of an entry that is due. A design that let the clear win would drop a live flow, and one that missed the read-cycle case would act on a stale time. Per-location report counts at the end catch duplicate or missing reports.

// File: rtl/flow_idle_pkg.sv
package flow_idle_pkg;
    typedef enum logic [1:0] {
        ST_WIPE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_JUDGE = 2'd2
    } scan_st_e;
endpackage

// File: rtl/idle_sec_timer.sv
module idle_sec_timer #(
    parameter int TS_W     = 8,
    parameter int PRESCALE = 1000000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_us,
    output logic [TS_W-1:0] now_sec
);
    localparam logic [TS_W-1:0] TOP_V = '1;
    localparam logic [TS_W-1:0] ONE_V = TS_W'(1);

    logic sec_step;

    generate
        if (PRESCALE == 1) begin : g_direct
            assign sec_step = tick_us;
        end else begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] PS_LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (tick_us) begin
                    pre_q <= (pre_q == PS_LAST) ? '0 : pre_q + 1'b1;
                end
            end
            assign sec_step = tick_us && (pre_q == PS_LAST);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_sec <= ONE_V;
        end else if (sec_step) begin
            now_sec <= (now_sec == TOP_V) ? ONE_V : now_sec + 1'b1;
        end
    end

    // R2
    now_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        now_sec != '0);
    // R2
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_us |=> $stable(now_sec));
endmodule

// File: rtl/idle_stamp_ram.sv
module idle_stamp_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_din,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we,
    input  logic [DW-1:0] b_din,
    output logic [DW-1:0] b_dout
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Port A (packet side) overrides port B on an address collision.
    always_ff @(posedge clk) begin
        b_dout <= mem[b_addr];
        if (b_we && !(a_we && a_addr == b_addr)) begin
            mem[b_addr] <= b_din;
        end
        if (a_we) begin
            mem[a_addr] <= a_din;
        end
    end
endmodule

// File: rtl/idle_flow_scanner.sv
module idle_flow_scanner
    import flow_idle_pkg::*;
#(
    parameter int LOC_W    = 10,
    parameter int TS_W     = 8,
    parameter int PRESCALE = 1000000,
    parameter int TIMEOUT  = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_us,
    input  logic             pkt_valid,
    input  logic [LOC_W-1:0] pkt_loc,
    output logic             del_valid,
    output logic [LOC_W-1:0] del_loc
);
    localparam logic [LOC_W-1:0] LAST_LOC = '1;
    localparam logic [TS_W-1:0]  TO_V     = TS_W'(TIMEOUT);

    scan_st_e         st_q, st_d;
    logic [LOC_W-1:0] scan_q;
    logic [TS_W-1:0]  now_sec;
    logic [TS_W-1:0]  stored;
    logic [TS_W-1:0]  age;
    logic             hit_fetch_q;
    logic             write_hit;
    logic             expire;
    logic             b_we;

    idle_sec_timer #(.TS_W(TS_W), .PRESCALE(PRESCALE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_us (tick_us),
        .now_sec (now_sec)
    );

    idle_stamp_ram #(.AW(LOC_W), .DW(TS_W)) u_ram (
        .clk    (clk),
        .a_we   (pkt_valid),
        .a_addr (pkt_loc),
        .a_din  (now_sec),
        .b_addr (scan_q),
        .b_we   (b_we),
        .b_din  ('0),
        .b_dout (stored)
    );

    // Cyclic age over 1..2^TS_W-1 (zero is skipped by the timer).
    always_comb begin
        age = now_sec - stored;
        if (now_sec < stored) begin
            age = age - 1'b1;
        end
    end

    assign write_hit = pkt_valid && (pkt_loc == scan_q);
    assign expire    = (st_q == ST_JUDGE) && (stored != '0) && (age >= TO_V)
                       && !hit_fetch_q && !write_hit;
    assign b_we      = (st_q == ST_WIPE) || expire;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_WIPE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WIPE:  st_d = (scan_q == LAST_LOC) ? ST_FETCH : ST_WIPE;
            ST_FETCH: st_d = ST_JUDGE;
            ST_JUDGE: st_d = ST_FETCH;
            default:  st_d = ST_WIPE;
        endcase
    end

    // Walker address and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q      <= '0;
            hit_fetch_q <= 1'b0;
            del_valid   <= 1'b0;
            del_loc     <= '0;
        end else begin
            hit_fetch_q <= (st_q == ST_FETCH) && write_hit;
            del_valid   <= expire;
            if (expire) begin
                del_loc <= scan_q;
            end
            if (st_q == ST_WIPE || st_q == ST_JUDGE) begin
                scan_q <= scan_q + 1'b1;
            end
        end
    end

    // R1
    wipe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WIPE) |-> !del_valid);
    // R4
    fetch_then_judge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FETCH) |=> (st_q == ST_JUDGE) && $stable(scan_q));
    // R5
    del_after_judge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        del_valid |-> ($past(st_q) == ST_JUDGE) && (del_loc == $past(scan_q)));
    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_JUDGE && pkt_valid && pkt_loc == scan_q) |=> !del_valid);
    // R9
    del_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        del_valid |=> !del_valid);
endmodule

// File: tb/idle_flow_scanner_bench.sv
module idle_flow_scanner_bench;
    localparam int LW    = 3;
    localparam int N     = 1 << LW;
    localparam int TW    = 4;
    localparam int PS    = 2;
    localparam int TO    = 3;
    localparam int TICKP = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_us = 1'b0;
    logic          pkt_valid = 1'b0;
    logic [LW-1:0] pkt_loc = '0;
    logic          del_valid;
    logic [LW-1:0] del_loc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int ecnt = -1;
    int presc_m = 0;
    int sec = 0;
    int sec_d1 = 0;
    int wr_sec [N];
    bit live [N];
    int dcount [N];
    int total_dels = 0;
    bit prev_del = 1'b0;
    bit refresh_on = 1'b0;
    int last_ref = -1;
    int sec_next = 0;

    always #5 clk = ~clk;

    idle_flow_scanner #(.LOC_W(LW), .TS_W(TW), .PRESCALE(PS), .TIMEOUT(TO)) u_idle_flow_scanner (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_us   (tick_us),
        .pkt_valid (pkt_valid),
        .pkt_loc   (pkt_loc),
        .del_valid (del_valid),
        .del_loc   (del_loc)
    );

    // Reference time base: absolute seconds counted from the tick pulses (R2).
    always @(posedge clk) begin
        if (!rst_n) begin
            ecnt    <= -1;
            presc_m <= 0;
            sec     <= 0;
            sec_d1  <= 0;
        end else begin
            ecnt   <= ecnt + 1;
            sec_d1 <= sec;
            if (tick_us) begin
                if (presc_m == PS - 1) begin
                    presc_m <= 0;
                    sec     <= sec + 1;
                end else begin
                    presc_m <= presc_m + 1;
                end
            end
        end
    end

    function automatic bit is_eval(input int a);
        return (ecnt >= N) && (((ecnt - N) % (2 * N)) == 2 * a);
    endfunction

    function automatic bit is_read(input int a);
        return (ecnt >= N - 1) && (((ecnt - N + 1) % (2 * N)) == 2 * a);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: observe outputs, then drive the tick; the packet strobe is left low.
    task automatic watch();
        @(negedge clk);
        if (del_valid) begin
            total_dels++;
            // R9: never two in a row
            check(!prev_del, "R9 back-to-back delete", 1, 0);
            // R5/R6: only live entries are reported
            check(live[del_loc], "R5/R6 report of a non-live entry", int'(del_loc), -1);
            // R5/R7: reported exactly TIMEOUT seconds after the last write
            check((sec_d1 - wr_sec[del_loc]) == TO, "R7 age at report",
                  sec_d1 - wr_sec[del_loc], TO);
            dcount[del_loc]++;
            live[del_loc] = 1'b0;
        end
        prev_del  = del_valid;
        tick_us   = ((ecnt % TICKP) == 5);
        sec_next  = sec + ((tick_us && presc_m == PS - 1) ? 1 : 0);
        pkt_valid = 1'b0;
    endtask

    // R3: the entry takes the seconds value of the current cycle
    task automatic drive(input int loc);
        pkt_valid = 1'b1;
        pkt_loc   = LW'(loc);
        wr_sec[loc] = sec;
        live[loc]   = 1'b1;
    endtask

    task automatic step_ref();
        watch();
        if (refresh_on && sec != last_ref) begin
            drive(6);
            last_ref = sec;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step_ref();
    endtask

    task automatic send(input int loc);
        watch();
        drive(loc);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            wr_sec[i] = 0;
            live[i]   = 1'b0;
            dcount[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(del_valid == 1'b0, "R1 del_valid in reset", int'(del_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R6: wipe and a quiet stretch with empty entries
        run(100);
        check(total_dels == 0, "R6 deletes with no flows", total_dels, 0);

        refresh_on = 1'b1;
        for (int i = 0; i < 4; i++) send(i);
        run(20);
        send(4);
        send(5);
        send(7);

        // R8 (with R4 cadence): write in read cycle of entry 4 and judge cycle of entry 7
        begin
            bit done4 = 1'b0;
            bit done7 = 1'b0;
            int guard = 0;
            while (!(done4 && done7) && guard < 400) begin
                guard++;
                watch();
                if (!done4 && live[4] && (sec_next - wr_sec[4]) == TO && is_read(4)) begin
                    drive(4);
                    done4 = 1'b1;
                end else if (!done7 && live[7] && (sec - wr_sec[7]) == TO && is_eval(7)) begin
                    drive(7);
                    done7 = 1'b1;
                end else if (refresh_on && sec != last_ref) begin
                    drive(6);
                    last_ref = sec;
                end
            end
            check(done4, "R8 read-cycle collision reached", int'(done4), 1);
            check(done7, "R8 judge-cycle collision reached", int'(done7), 1);
            check(dcount[4] == 0 && dcount[7] == 0, "R8 delete despite write",
                  dcount[4] + dcount[7], 0);
        end
        run(120);

        // Second and third rounds straddle counter wraparound (R7)
        for (int i = 0; i < 4; i++) send(i);
        run(120);
        send(0);
        send(1);
        run(120);
        refresh_on = 1'b0;
        run(120);

        // R5: one report per write that was left idle; R8 refreshed entries once
        check(dcount[0] == 3, "R5 count loc0", dcount[0], 3);
        check(dcount[1] == 3, "R5 count loc1", dcount[1], 3);
        check(dcount[2] == 2, "R5 count loc2", dcount[2], 2);
        check(dcount[3] == 2, "R5 count loc3", dcount[3], 2);
        check(dcount[4] == 1, "R8 count loc4", dcount[4], 1);
        check(dcount[5] == 1, "R5 count loc5", dcount[5], 1);
        check(dcount[6] == 1, "R5 count refreshed loc6", dcount[6], 1);
        check(dcount[7] == 1, "R8 count loc7", dcount[7], 1);
        check(sec >= 2 * ((1 << TW) - 1), "R7 counter wrapped twice", sec, 2 * ((1 << TW) - 1));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule